// File: doc/BRIEF.md
# Six-Channel PWM Bank with Complementary Outputs

This block generates six free-running pulse-width-modulated waveforms. Each channel drives a main pin and a complementary pin. All channels that use the fast time base share one programmable prescaler. Each channel holds a 16-bit compare value and a 16-bit period value. Its counter climbs from zero to period minus one and then wraps. Before any inversion, the main waveform is active while the count is below the compare value. A polarity bit moves the active phase to the part of the period after the compare point. The main pin and the complementary pin each have their own inversion bit.

Any channel can be moved off the prescaler onto a slow time base. The slow time base arrives as `slow_tick`, a one-cycle pulse that is already synchronous to `clk`, once per slow-clock period. On a fast channel, newly written compare and period values are held as pending values and take effect only at the next period wrap, so the waveform never contains a partial cycle. On a slow channel, pending values take effect only when software writes the update strobe. Software controls the block through a plain write port and a combinational read port. Both use a 6-bit word address and 16-bit data.

Register map (word addresses): 0x00 prescaler divider (8 bits); 0x01 channel 0 enable in bit 0; 0x02 channel 1..5 enables in bits 1..5; 0x03 main-pin invert mask; 0x04 complementary-pin invert mask; 0x05 polarity mask; 0x06 slow-clock select mask; 0x07 update strobe (write bit 0 = 1). Channel i has its compare value at 0x10+2i and its period value at 0x11+2i. In every mask, bit i belongs to channel i.

Top module: `pwm_bank`

## Requirements
- R1: The prescaler raises its tick once every (divider+1) clock cycles, with the divider at address 0x00. A fast channel advances its count once per tick, so its waveform repeats every (divider+1)*period clock cycles.
- R2: A running channel counts from 0 to period-1 and then wraps to 0; a period of 0 counts as 1. With polarity 0, the raw waveform is 1 while count < compare, so a compare value of at least the period gives a raw waveform that is always 1, and a compare value of 0 gives one that is always 0.
- R3: After reset every register reads 0 and every pin is 0. A disabled channel holds its count at 0. On a disabled channel, the main and complementary levels are both 0 before inversion, so each pin shows its own invert bit.
- R4: The enable for channel 0 is bit 0 of address 0x01. The enables for channels 1..5 are bits 1..5 of address 0x02. Bit 0 of address 0x02 is ignored, and a write to either address leaves the enables held at the other address unchanged.
- R5: Bit i of address 0x03 inverts the main pin of channel i.
- R6: The complementary pin of a running channel carries the inverse of the raw main waveform, XOR bit i of address 0x04.
- R7: Bit i of address 0x05 set makes the raw waveform of channel i equal to 1 while count >= compare.
- R8: Bit i of address 0x06 set makes channel i advance only on `slow_tick` pulses, independent of the divider. With no `slow_tick` pulses, its pins stay constant.
- R9: On a slow channel, written compare and period values take effect only at the clock edge that writes 1 to bit 0 of address 0x07. Until that edge the running waveform is unchanged.
- R10: On a fast channel, written compare and period values take effect at the next period wrap, or at once while the channel is disabled. Every high pulse therefore has either the old length or the new length, never a mixture.
- R11: `rd_data` shows, in the same cycle, the register selected by `rd_addr`. Bit 0 of address 0x02 reads 0, address 0x07 reads 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write word address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 6 | Read word address |
| rd_data | output | 16 | Read data for rd_addr |
| pwm_out | output | 6 | Main PWM pins, bit i for channel i |
| pwm_n_out | output | 6 | Complementary PWM pins, bit i for channel i |

## Verification
A wrong internal state shows up on the pins within one waveform period. A counter that runs too far or wraps early changes the number of high cycles counted over a whole number of periods. A bad prescaler phase scales that count by the wrong factor. A compare value applied at the wrong moment produces a high pulse whose length is neither the old length nor the new one, and this shows up within the period in which the write lands. A slow channel that applies its values before the strobe shows the new duty cycle well before the bench issues the strobe. A complementary pin that drifts from the main pin shows up as a single mismatching sample.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Register word addresses
  localparam int A_DIV     = 0;
  localparam int A_EN_LO   = 1;
  localparam int A_EN_HI   = 2;
  localparam int A_INV     = 3;
  localparam int A_NINV    = 4;
  localparam int A_POL     = 5;
  localparam int A_SLOW    = 6;
  localparam int A_UPD     = 7;
  localparam int A_CH_BASE = 16;

  // Per-channel static configuration as seen by a channel
  typedef struct packed {
    logic en;
    logic slow_sel;
    logic pol;
    logic inv_main;
    logic inv_n;
  } ch_cfg_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] pre_cnt;

  // Tick on the last count of the divide window; >= tolerates a divider lowered mid-window
  assign tick = (pre_cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_cnt <= '0;
    else if (tick) pre_cnt <= '0;
    else           pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int CW   = 16,
  parameter int DIVW = 8,
  parameter int AW   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [CW-1:0]           rd_data,
  output logic [DIVW-1:0]         div_q,
  output logic [NCH-1:0]          en_q,
  output logic [NCH-1:0]          inv_q,
  output logic [NCH-1:0]          ninv_q,
  output logic [NCH-1:0]          pol_q,
  output logic [NCH-1:0]          slow_q,
  output logic                    upd_strobe,
  output logic [NCH-1:0][CW-1:0]  pend_cmp,
  output logic [NCH-1:0][CW-1:0]  pend_max
);
  function automatic logic hit(input logic [AW-1:0] a, input int target);
    return a == AW'(target);
  endfunction

  assign upd_strobe = wr_en && hit(wr_addr, A_UPD) && wr_data[0];

  // Shared control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      en_q   <= '0;
      inv_q  <= '0;
      ninv_q <= '0;
      pol_q  <= '0;
      slow_q <= '0;
    end else if (wr_en) begin
      if (hit(wr_addr, A_DIV))   div_q  <= wr_data[DIVW-1:0];
      if (hit(wr_addr, A_EN_LO)) en_q[0] <= wr_data[0];
      if (hit(wr_addr, A_EN_HI)) en_q[NCH-1:1] <= wr_data[NCH-1:1];
      if (hit(wr_addr, A_INV))   inv_q  <= wr_data[NCH-1:0];
      if (hit(wr_addr, A_NINV))  ninv_q <= wr_data[NCH-1:0];
      if (hit(wr_addr, A_POL))   pol_q  <= wr_data[NCH-1:0];
      if (hit(wr_addr, A_SLOW))  slow_q <= wr_data[NCH-1:0];
    end
  end

  // Pending compare/period words, one pair per channel
  for (genvar i = 0; i < NCH; i++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_cmp[i] <= '0;
        pend_max[i] <= '0;
      end else if (wr_en) begin
        if (hit(wr_addr, A_CH_BASE + 2*i))     pend_cmp[i] <= wr_data;
        if (hit(wr_addr, A_CH_BASE + 2*i + 1)) pend_max[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit(rd_addr, A_DIV))   rd_data = CW'(div_q);
    if (hit(rd_addr, A_EN_LO)) rd_data = CW'(en_q[0]);
    if (hit(rd_addr, A_EN_HI)) rd_data = CW'({en_q[NCH-1:1], 1'b0});
    if (hit(rd_addr, A_INV))   rd_data = CW'(inv_q);
    if (hit(rd_addr, A_NINV))  rd_data = CW'(ninv_q);
    if (hit(rd_addr, A_POL))   rd_data = CW'(pol_q);
    if (hit(rd_addr, A_SLOW))  rd_data = CW'(slow_q);
    for (int i = 0; i < NCH; i++) begin
      if (hit(rd_addr, A_CH_BASE + 2*i))     rd_data = pend_cmp[i];
      if (hit(rd_addr, A_CH_BASE + 2*i + 1)) rd_data = pend_max[i];
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ch_cfg_t       cfg,
  input  logic          fast_tick,
  input  logic          slow_tick,
  input  logic          upd_strobe,
  input  logic [CW-1:0] pend_cmp,
  input  logic [CW-1:0] pend_max,
  output logic          out_main,
  output logic          out_n,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] act_cmp_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt, act_cmp, act_max;
  logic          tick, last, load, raw;

  assign tick = cfg.slow_sel ? slow_tick : fast_tick;
  // Treat a period of 0 like 1: the count then stays at 0
  assign last = ({1'b0, cnt} + 1'b1) >= {1'b0, act_max};
  assign wrap_o = cfg.en && tick && last;
  // Slow channels take new values only on the strobe; fast ones at the wrap or while idle
  assign load = cfg.slow_sel ? upd_strobe : (!cfg.en || wrap_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_cmp <= '0;
      act_max <= '0;
    end else begin
      if (!cfg.en)   cnt <= '0;
      else if (tick) cnt <= last ? '0 : cnt + 1'b1;
      if (load) begin
        act_cmp <= pend_cmp;
        act_max <= pend_max;
      end
    end
  end

  assign raw      = cfg.pol ? (cnt >= act_cmp) : (cnt < act_cmp);
  assign out_main = (cfg.en & raw) ^ cfg.inv_main;
  assign out_n    = (cfg.en & ~raw) ^ cfg.inv_n;

  assign cnt_o     = cnt;
  assign act_cmp_o = act_cmp;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int CW   = 16,
  parameter int DIVW = 8,
  parameter int AW   = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slow_tick,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [CW-1:0]  rd_data,
  output logic [NCH-1:0] pwm_out,
  output logic [NCH-1:0] pwm_n_out
);
  logic [DIVW-1:0]        div_q;
  logic [NCH-1:0]         en_q, inv_q, ninv_q, pol_q, slow_q, wrap_vec;
  logic                   upd_strobe, fast_tick;
  logic [NCH-1:0][CW-1:0] pend_cmp, pend_max, cnt_arr, act_cmp_arr;

  pwm_regs #(.NCH(NCH), .CW(CW), .DIVW(DIVW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .div_q(div_q), .en_q(en_q), .inv_q(inv_q), .ninv_q(ninv_q),
    .pol_q(pol_q), .slow_q(slow_q), .upd_strobe(upd_strobe),
    .pend_cmp(pend_cmp), .pend_max(pend_max)
  );

  pwm_prescaler #(.DIVW(DIVW)) u_pre (
    .clk(clk), .rst_n(rst_n), .div(div_q), .tick(fast_tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ch_cfg_t cfg;
    assign cfg = '{en: en_q[i], slow_sel: slow_q[i], pol: pol_q[i],
                   inv_main: inv_q[i], inv_n: ninv_q[i]};
    pwm_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .cfg(cfg),
      .fast_tick(fast_tick), .slow_tick(slow_tick), .upd_strobe(upd_strobe),
      .pend_cmp(pend_cmp[i]), .pend_max(pend_max[i]),
      .out_main(pwm_out[i]), .out_n(pwm_n_out[i]),
      .cnt_o(cnt_arr[i]), .act_cmp_o(act_cmp_arr[i]), .wrap_o(wrap_vec[i])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH = 6,
  parameter int CW  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   slow_tick,
  input logic                   fast_tick,
  input logic                   upd_strobe,
  input logic [NCH-1:0]         en_q,
  input logic [NCH-1:0]         slow_q,
  input logic [NCH-1:0]         inv_q,
  input logic [NCH-1:0]         ninv_q,
  input logic [NCH-1:0]         wrap_vec,
  input logic [NCH-1:0]         pwm_out,
  input logic [NCH-1:0]         pwm_n_out,
  input logic [NCH-1:0][CW-1:0] cnt_arr,
  input logic [NCH-1:0][CW-1:0] act_cmp_arr
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[i] |-> (pwm_out[i] == inv_q[i]) && (pwm_n_out[i] == ninv_q[i])); // R3
    AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[i] |=> cnt_arr[i] == '0); // R3
    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      en_q[i] |-> (pwm_n_out[i] ^ ninv_q[i]) != (pwm_out[i] ^ inv_q[i])); // R6
    AST_FAST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && !slow_q[i] && !fast_tick) |=> $stable(cnt_arr[i])); // R1
    AST_SLOW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && slow_q[i] && !slow_tick) |=> $stable(cnt_arr[i])); // R8
    AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_q[i] && !upd_strobe) |=> $stable(act_cmp_arr[i])); // R9
    AST_FAST_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && !slow_q[i] && !wrap_vec[i]) |=> $stable(act_cmp_arr[i])); // R10
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .CW(CW)) u_pwm_bank_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
  .upd_strobe(upd_strobe), .en_q(en_q), .slow_q(slow_q), .inv_q(inv_q),
  .ninv_q(ninv_q), .wrap_vec(wrap_vec), .pwm_out(pwm_out),
  .pwm_n_out(pwm_n_out), .cnt_arr(cnt_arr), .act_cmp_arr(act_cmp_arr)
);

// File: tb/test_pwm_bank.sv
module test_pwm_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int CW  = 16;
  localparam int AW  = 6;
  localparam int SLOW_DIV = 4;

  logic           clk = 0, rst_n = 0, slow_tick = 0, wr_en = 0;
  logic [AW-1:0]  wr_addr = '0, rd_addr = '0;
  logic [CW-1:0]  wr_data = '0, rd_data;
  logic [NCH-1:0] pwm_out, pwm_n_out;

  int checks = 0, fails = 0;
  bit slow_gen = 0, done = 0;
  int sl_cnt = 0;

  pwm_bank i_pwm_bank (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pwm_out(pwm_out), .pwm_n_out(pwm_n_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (slow_gen) begin
      sl_cnt = (sl_cnt + 1) % SLOW_DIV;
      slow_tick <= (sl_cnt == 0);
    end else slow_tick <= 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = a[AW-1:0]; wr_data = d[CW-1:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = a[AW-1:0];
    #1;
    d = int'(rd_data);
  endtask

  // Counts over len consecutive negedge samples
  task automatic measure(input int ch, input int len, input bit ci, input bit cn,
                         output int hm, output int hn, output int bad, output int edges);
    bit prev;
    hm = 0; hn = 0; bad = 0; edges = 0;
    prev = pwm_out[ch];
    for (int k = 0; k < len; k++) begin
      if (pwm_out[ch]) hm++;
      if (pwm_n_out[ch]) hn++;
      if ((pwm_n_out[ch] ^ cn) == (pwm_out[ch] ^ ci)) bad++;
      if (pwm_out[ch] != prev) edges++;
      prev = pwm_out[ch];
      @(negedge clk);
    end
  endtask

  task automatic enable_only(input int ch);
    if (ch == 0) wr(1, 1);
    else         wr(2, 1 << ch);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, hm, hn, bad, edges;
    int cs[6] = '{0, 3, 5, 7, 1, 2};
    int ms[6] = '{5, 5, 5, 5, 1, 3};

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // Reset state
    check(pwm_out == '0, "R3 reset main pins", int'(pwm_out), 0);
    check(pwm_n_out == '0, "R3 reset complementary pins", int'(pwm_n_out), 0);
    rd(0, v); check(v == 0, "R3 reset divider", v, 0);
    rd(6, v); check(v == 0, "R3 reset slow mask", v, 0);

    // Register read-back
    wr(0, 'hA5);     rd(0, v);  check(v == 'hA5, "R11 divider readback", v, 'hA5);
    wr(26, 'hBEEF);  rd(26, v); check(v == 'hBEEF, "R11 ch5 compare readback", v, 'hBEEF);
    wr(27, 'h1234);  rd(27, v); check(v == 'h1234, "R11 ch5 period readback", v, 'h1234);
    wr(2, 'h3F);     rd(2, v);  check(v == 'h3E, "R11 R4 high enable readback", v, 'h3E);
    rd(1, v);  check(v == 0, "R4 ch0 enable untouched by 0x02", v, 0);
    wr(7, 1);  rd(7, v); check(v == 0, "R11 strobe reads zero", v, 0);
    rd(40, v); check(v == 0, "R11 unmapped reads zero", v, 0);
    wr(2, 0); wr(0, 0);

    // Enable addressing
    for (int c = 0; c < NCH; c++) begin
      wr(16 + 2*c, 2); wr(17 + 2*c, 4);
    end
    wr(2, 'h3F);
    repeat (8) @(negedge clk);
    measure(0, 8, 0, 0, hm, hn, bad, edges);
    check(hm == 0, "R4 ch0 stays off on 0x02 bit0", hm, 0);
    measure(3, 8, 0, 0, hm, hn, bad, edges);
    check(hm == 4, "R4 ch3 runs from 0x02", hm, 4);
    wr(1, 1);
    repeat (8) @(negedge clk);
    measure(0, 8, 0, 0, hm, hn, bad, edges);
    check(hm == 4, "R4 ch0 runs from 0x01", hm, 4);
    wr(2, 0);
    repeat (8) @(negedge clk);
    measure(0, 8, 0, 0, hm, hn, bad, edges);
    check(hm == 4, "R4 ch0 unaffected by clearing 0x02", hm, 4);
    measure(3, 8, 0, 0, hm, hn, bad, edges);
    check(hm == 0, "R4 ch3 stopped", hm, 0);
    wr(1, 0);

    // Sweep: channel x divider x (compare, period) x (pol, inv, ninv)
    for (int ch = 0; ch < NCH; ch++)
      for (int d = 0; d <= 2; d += 2)
        for (int p = 0; p < 6; p++)
          for (int m = 0; m < 8; m++) begin
            bit pol, ci, cn;
            int per, act, raw, w, exp_m, exp_n;
            pol = m[0]; ci = m[1]; cn = m[2];
            wr(1, 0); wr(2, 0);
            wr(0, d);
            wr(16 + 2*ch, cs[p]); wr(17 + 2*ch, ms[p]);
            wr(5, pol << ch); wr(3, ci << ch); wr(4, cn << ch);
            check(pwm_out[ch] == ci && pwm_n_out[ch] == cn, "R3 idle pins show invert bits",
                  {pwm_out[ch], pwm_n_out[ch]}, {ci, cn});
            enable_only(ch);
            per = (d + 1) * ms[p];
            repeat (per + d + 3) @(negedge clk);
            w = 2 * per;
            act = (cs[p] < ms[p]) ? cs[p] : ms[p];
            raw = (pol ? (ms[p] - act) : act) * (d + 1) * 2;
            exp_m = ci ? (w - raw) : raw;
            exp_n = cn ? raw : (w - raw);
            measure(ch, w, ci, cn, hm, hn, bad, edges);
            check(hm == exp_m, "R1 R2 R5 R7 main high cycles", hm, exp_m);
            check(hn == exp_n && bad == 0, "R6 complementary pin", hn, exp_n);
          end
    wr(1, 0); wr(2, 0); wr(0, 0); wr(3, 0); wr(4, 0); wr(5, 0);

    // Fast update applied only at wrap
    begin
      int plen, badp;
      bit prev, seen;
      wr(18, 2); wr(19, 8);
      wr(2, 2);
      repeat (12) @(negedge clk);
      repeat (3) @(negedge clk);
      wr(18, 6);
      plen = 0; badp = 0; seen = 0; prev = pwm_out[1];
      for (int k = 0; k < 48; k++) begin
        if (pwm_out[1] && !prev) begin seen = 1; plen = 0; end
        if (pwm_out[1]) plen++;
        if (!pwm_out[1] && prev && seen && plen != 2 && plen != 6) badp++;
        prev = pwm_out[1];
        @(negedge clk);
      end
      check(badp == 0, "R10 no partial pulse", badp, 0);
      measure(1, 16, 0, 0, hm, hn, bad, edges);
      check(hm == 12, "R10 new compare in effect", hm, 12);
      wr(2, 0);
    end

    // Slow clock channel
    slow_gen = 1;
    wr(0, 7);
    wr(6, 1 << 2);
    wr(20, 1); wr(21, 4);
    wr(7, 1);
    wr(2, 1 << 2);
    repeat (16 + SLOW_DIV + 3) @(negedge clk);
    measure(2, 32, 0, 0, hm, hn, bad, edges);
    check(hm == 8, "R8 slow channel duty from slow ticks", hm, 8);
    wr(20, 3);
    repeat (64) @(negedge clk);
    measure(2, 32, 0, 0, hm, hn, bad, edges);
    check(hm == 8, "R9 slow channel holds old compare", hm, 8);
    wr(7, 1);
    repeat (16 + SLOW_DIV + 3) @(negedge clk);
    measure(2, 32, 0, 0, hm, hn, bad, edges);
    check(hm == 24, "R9 strobe applies new compare", hm, 24);
    slow_gen = 0;
    repeat (SLOW_DIV + 2) @(negedge clk);
    measure(2, 32, 0, 0, hm, hn, bad, edges);
    check(edges == 0, "R8 no slow ticks freezes pins", edges, 0);
    check(bad == 0, "R6 complement on frozen slow channel", bad, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule